// File: doc/BRIEF.md
# Register-programmed SPI master

This block is an SPI master peripheral that software drives through a small register bus with separate write and read strobes, a 3-bit word address and 32-bit data. Software sets the frame width, clock polarity and phase, the clock divisor and the number of frames while the block is disabled. It selects one slave through a one-hot select register and then sets the enable bit. From that point the block moves the programmed number of frames through a transmit FIFO and a receive FIFO. Each frame sent captures one frame from the slave, most significant bit first. When the last frame is done the block leaves the busy state and stops by itself. Software pushes transmit words and pops receive words by polling the status word.

The transfer engine is a four-state machine. In **IDLE** nothing moves. The transition *start* (enable set) leads to **WAIT**. In WAIT the engine holds SCLK at its idle level until the transmit FIFO has a word and the receive FIFO has room. The transition *load* pops that word and enters **SHIFT**. SHIFT toggles SCLK once per half period. On the last edge of a frame the engine pushes the received word and takes one of two transitions. *next* returns to WAIT when frames remain. *finish* enters **DONE** after the final frame. DONE holds until software clears enable. The transition *abort* (enable cleared) returns to IDLE from any state. It also empties both FIFOs.

Register addresses: 0 control, 1 frame count, 2 divisor, 3 enable, 4 select, 5 status, 6 transmit data (write), 7 receive data (read).

Top module: `spim_core`

## Requirements
- R1: The SCLK half period lasts H clock cycles. H is half of the effective divisor. The effective divisor is bits 15:0 of the divisor register (address 2) with bit 0 cleared, and an effective value of 0 becomes 2. Every SCLK edge inside a frame follows the previous edge by exactly H cycles.
- R2: The frame-count register (address 1, bits 15:0) holds N-1. After enable the block moves exactly N frames. It then clears busy, stays stopped and shows no further SCLK edges.
- R3: Writes to the control, frame-count and divisor registers are ignored while enable is 1. A readback returns the value held before the write.
- R4: Writing 1 to bit 0 of address 3 starts the block. Writing 0 aborts any transfer: SCLK returns to idle, busy clears and both FIFOs are emptied. Transmit-data writes made while the block is disabled are dropped.
- R5: Each FIFO holds 32 entries. The transmit-full flag is set when 32 words wait. A transmit write made while the FIFO is full is dropped and never reaches the line.
- R6: Status (address 5) bit 0 is busy, bit 1 is transmit FIFO full and bit 2 is receive FIFO empty. All other bits read 0.
- R7: Writing a value with at most one bit set to address 4 drives the matching cs_n bit low, or all bits high for 0. This works independently of enable. A write with two or more bits set, or with any bit at or above NSEL, is ignored.
- R8: Control bit 0 selects 16-bit frames (1) or 8-bit frames (0). Transmit words are sent MSB first using their low 8 or 16 bits. Received frames are read from address 7 zero-extended, in arrival order, one per transmitted frame.
- R9: Control bit 1 (CPOL) sets the SCLK idle level to high. Control bit 2 (CPHA) makes both sides sample on the second edge of each bit instead of the first. All four modes transfer data correctly, and SCLK sits at its idle level whenever the block is not busy.
- R10: When the enable write is accepted on clock edge E and a transmit word is written on edge E+1, the first SCLK edge occurs on edge E+2+H. This leaves one half period between loading the frame and its first edge.
- R11: When the transmit FIFO runs empty before the last frame, SCLK stays idle and busy stays 1 until a word arrives. Transfer then resumes.
- R12: While the receive FIFO holds 32 words, no new frame starts. The transfer resumes once software reads a word, and no received frame is lost.
- R13: A read of address 7 while the receive FIFO is empty returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 7) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from the selected slave |
| cs_n | output | NSEL | Active-low slave selects |

## Verification
The hardest situation to reach is the receive-full stall. The block must have finished 32 frames that software never read, while further frames are still owed. The bench programs a 64-frame transfer at the fastest divisor. It pushes 32 words, waits without reading until the engine parks in WAIT, and then refills the transmit FIFO to full plus one extra word. This shows in a single scenario the stall, the full flag and the dropped write. The bench then drains the receive FIFO and checks that every one of the 64 frames arrives in both directions in order.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Register word addresses; software layout of the block
    typedef enum logic [2:0] {
        ADDR_CTRL  = 3'd0,
        ADDR_COUNT = 3'd1,
        ADDR_DIV   = 3'd2,
        ADDR_EN    = 3'd3,
        ADDR_SEL   = 3'd4,
        ADDR_STAT  = 3'd5,
        ADDR_TXD   = 3'd6,
        ADDR_RXD   = 3'd7
    } spim_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT,
        ST_DONE
    } spim_state_e;

    // Packed so that wide is bit 0, cpol bit 1, cpha bit 2
    typedef struct packed {
        logic cpha;
        logic cpol;
        logic wide;
    } spim_cfg_t;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (clear) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 16,
    parameter int HALF_W  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  spim_cfg_t          cfg,
    input  logic [CNT_W-1:0]   frames_m1,
    input  logic [HALF_W-1:0]  half,
    input  logic               tx_avail,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               rx_space,
    input  logic               miso,
    output logic               tx_pop,
    output logic               rx_push,
    output logic [FRAME_W-1:0] rx_data,
    output logic               busy,
    output logic               sclk,
    output logic               mosi
);
    localparam int NARROW = FRAME_W / 2;
    localparam int EC_W   = $clog2(2 * FRAME_W);

    spim_state_e        state, state_nx;
    logic [HALF_W-1:0]  hcnt;
    logic [EC_W-1:0]    edge_cnt;
    logic [CNT_W-1:0]   fcnt;
    logic [FRAME_W-1:0] tx_sh, rx_sh, nxt_rx;
    logic               phase;
    logic               load_ok, edge_now, last_edge, sample_now, shift_now, final_frame;

    assign load_ok     = (state == ST_WAIT) && enable && tx_avail && rx_space;
    assign edge_now    = (state == ST_SHIFT) && enable && (hcnt == half - 1'b1);
    assign last_edge   = (edge_cnt == (cfg.wide ? EC_W'(2 * FRAME_W - 1) : EC_W'(2 * NARROW - 1)));
    assign final_frame = (fcnt == frames_m1);
    // phase 0 -> 1 is the leading edge of a bit
    assign sample_now  = edge_now && (cfg.cpha ? phase : !phase);
    assign shift_now   = edge_now && (cfg.cpha ? (!phase && edge_cnt != '0) : phase);
    assign nxt_rx      = sample_now ? {rx_sh[FRAME_W-2:0], miso} : rx_sh;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (enable) state_nx = ST_WAIT;               // start
            ST_WAIT:  if (load_ok) state_nx = ST_SHIFT;             // load
            ST_SHIFT: if (edge_now && last_edge)
                          state_nx = final_frame ? ST_DONE : ST_WAIT; // finish / next
            ST_DONE:  state_nx = ST_DONE;
        endcase
        if (!enable) state_nx = ST_IDLE;                            // abort
    end

    // Shift datapath and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt     <= '0;
            edge_cnt <= '0;
            fcnt     <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            phase    <= 1'b0;
        end else if (!enable || state == ST_IDLE) begin
            hcnt     <= '0;
            edge_cnt <= '0;
            fcnt     <= '0;
            phase    <= 1'b0;
        end else if (load_ok) begin
            tx_sh    <= cfg.wide ? tx_data : {tx_data[NARROW-1:0], {NARROW{1'b0}}};
            rx_sh    <= '0;
            hcnt     <= '0;
            edge_cnt <= '0;
        end else if (state == ST_SHIFT) begin
            if (edge_now) begin
                hcnt  <= '0;
                phase <= !phase;
                rx_sh <= nxt_rx;
                if (shift_now) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                if (last_edge) begin
                    edge_cnt <= '0;
                    fcnt     <= fcnt + 1'b1;
                end else begin
                    edge_cnt <= edge_cnt + 1'b1;
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = (state == ST_WAIT) || (state == ST_SHIFT);
        sclk    = cfg.cpol ^ phase;
        mosi    = tx_sh[FRAME_W-1];
        tx_pop  = load_ok;
        rx_push = edge_now && last_edge;
        rx_data = cfg.wide ? nxt_rx : {{NARROW{1'b0}}, nxt_rx[NARROW-1:0]};
    end

endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int NSEL       = 4,
    parameter int FIFO_DEPTH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [2:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] cs_n
);
    localparam int BUS_W   = 32;
    localparam int FRAME_W = 16;
    localparam int CNT_W   = 16;
    localparam int DIV_W   = 16;
    localparam int HALF_W  = DIV_W - 1;

    spim_cfg_t          cfg_q;
    logic [CNT_W-1:0]   count_q;
    logic [DIV_W-1:0]   div_q, div_even;
    logic [HALF_W-1:0]  half;
    logic               en_q;
    logic [NSEL-1:0]    sel_q;
    spim_addr_e         addr;

    logic               tx_push, tx_pop, tx_full, tx_empty;
    logic               rx_push, rx_pop, rx_full, rx_empty;
    logic [FRAME_W-1:0] tx_head, rx_head, rx_word;
    logic               eng_busy;
    logic               sel_ok;

    assign addr     = spim_addr_e'(bus_addr);
    assign div_even = {div_q[DIV_W-1:1], 1'b0};
    assign half     = (div_even == '0) ? HALF_W'(1) : div_even[DIV_W-1:1];
    assign sel_ok   = $onehot0(bus_wdata[NSEL-1:0]) && ((bus_wdata >> NSEL) == '0);
    assign tx_push  = bus_wr && en_q && (addr == ADDR_TXD);
    assign rx_pop   = bus_rd && (addr == ADDR_RXD);
    assign cs_n     = ~sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            count_q <= '0;
            div_q   <= '0;
            en_q    <= 1'b0;
            sel_q   <= '0;
        end else if (bus_wr) begin
            unique case (addr)
                ADDR_CTRL:  if (!en_q) cfg_q   <= spim_cfg_t'(bus_wdata[2:0]);
                ADDR_COUNT: if (!en_q) count_q <= bus_wdata[CNT_W-1:0];
                ADDR_DIV:   if (!en_q) div_q   <= bus_wdata[DIV_W-1:0];
                ADDR_EN:    en_q <= bus_wdata[0];
                ADDR_SEL:   if (sel_ok) sel_q <= bus_wdata[NSEL-1:0];
                ADDR_STAT, ADDR_TXD, ADDR_RXD: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CTRL:  bus_rdata = {{(BUS_W-3){1'b0}}, cfg_q};
            ADDR_COUNT: bus_rdata = {{(BUS_W-CNT_W){1'b0}}, count_q};
            ADDR_DIV:   bus_rdata = {{(BUS_W-DIV_W){1'b0}}, div_q};
            ADDR_EN:    bus_rdata = {{(BUS_W-1){1'b0}}, en_q};
            ADDR_SEL:   bus_rdata = {{(BUS_W-NSEL){1'b0}}, sel_q};
            ADDR_STAT:  bus_rdata = {{(BUS_W-3){1'b0}}, rx_empty, tx_full, eng_busy};
            ADDR_TXD:   bus_rdata = '0;
            ADDR_RXD:   bus_rdata = rx_empty ? '0 : {{(BUS_W-FRAME_W){1'b0}}, rx_head};
        endcase
    end

    spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clear(!en_q),
        .push(tx_push), .push_data(bus_wdata[FRAME_W-1:0]),
        .pop(tx_pop), .head(tx_head), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clear(!en_q),
        .push(rx_push), .push_data(rx_word),
        .pop(rx_pop), .head(rx_head), .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .HALF_W(HALF_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(en_q), .cfg(cfg_q),
        .frames_m1(count_q), .half(half),
        .tx_avail(!tx_empty), .tx_data(tx_head), .rx_space(!rx_full),
        .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
        .busy(eng_busy), .sclk(sclk), .mosi(mosi)
    );

endmodule

// File: rtl/spim_checks.sv
module spim_checks #(
    parameter int NSEL = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_q,
    input logic            busy,
    input logic [2:0]      cfg,
    input logic            sclk,
    input logic [NSEL-1:0] cs_n,
    input logic            rx_push,
    input logic            rx_full,
    input logic            tx_pop,
    input logic            tx_empty
);
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg[1]));

    p_abort_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !busy);

    p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && $past(en_q)) |-> $stable(cfg));

    p_no_rx_loss_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);

    p_load_has_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
endmodule

bind spim_core spim_checks #(.NSEL(NSEL)) u_checks (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .busy(eng_busy), .cfg(cfg_q),
    .sclk(sclk), .cs_n(cs_n), .rx_push(rx_push), .rx_full(rx_full),
    .tx_pop(tx_pop), .tx_empty(tx_empty)
);

// File: tb/spim_core_bench.sv
module spim_core_bench;
    localparam logic [2:0] A_CTRL = 3'd0, A_COUNT = 3'd1, A_DIV = 3'd2, A_EN = 3'd3,
                           A_SEL = 3'd4, A_STAT = 3'd5, A_TXD = 3'd6, A_RXD = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;

    always #10 clk = ~clk;

    spim_core u_spim_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int cmp_cnt = 0, bad_cnt = 0, cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        cmp_cnt++;
        if (act !== exp) begin
            bad_cnt++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference state
    logic        m_cpol = 0, m_cpha = 0, m_wide = 0;
    int          m_half = 1;
    logic [3:0]  m_sel = '0;
    logic [15:0] reply_q[$], exp_rx_q[$], got_q[$], sent_q[$];
    logic [15:0] s_out = '0, cap = '0, cur_reply = '0;
    int          ec = 0, last_edge_cyc = 0, first_edge_cyc = -1, en_cyc = 0;
    logic        mon_on = 0, prev_sclk = 0;

    assign miso = s_out[15];

    function automatic logic [15:0] fit(input logic [15:0] w);
        return m_wide ? w : {8'h00, w[7:0]};
    endfunction

    task automatic next_reply();
        cur_reply = (reply_q.size() > 0) ? reply_q.pop_front() : 16'h0000;
        s_out = m_wide ? cur_reply : {cur_reply[7:0], 8'h00};
    endtask

    // Slave model and per-clock comparison, sampled away from both clock edges
    always @(posedge clk) begin
        #5;
        if (rst_n) chk("R7 cs_n vs select model", {28'd0, cs_n}, {28'd0, ~m_sel});
        if (rst_n && mon_on && sclk !== prev_sclk) begin
            if (first_edge_cyc < 0) first_edge_cyc = cyc;
            if (ec > 0) chk("R1 half-period spacing", cyc - last_edge_cyc, m_half);
            last_edge_cyc = cyc;
            if (sclk != m_cpol) begin          // leading edge
                if (!m_cpha) cap = {cap[14:0], mosi};
                else if (ec > 0) s_out = {s_out[14:0], 1'b0};
            end else begin                      // trailing edge
                if (!m_cpha) s_out = {s_out[14:0], 1'b0};
                else cap = {cap[14:0], mosi};
            end
            ec++;
            if (ec == (m_wide ? 32 : 16)) begin
                got_q.push_back(fit(cap));
                exp_rx_q.push_back(fit(cur_reply));
                ec = 0;
                cap = '0;
                next_reply();
            end
        end
        prev_sclk = sclk;
    end

    // Bus access tasks: called at a falling edge, return at the next one
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic configure(input logic wide, input logic cpol, input logic cpha, input logic [15:0] dv);
        logic [15:0] d;
        m_wide = wide; m_cpol = cpol; m_cpha = cpha;
        d = dv & 16'hFFFE;
        if (d == 0) d = 16'd2;
        m_half = int'(d) / 2;
        wr(A_CTRL, {29'd0, cpha, cpol, wide});
        wr(A_DIV, {16'd0, dv});
        reply_q.delete(); exp_rx_q.delete(); got_q.delete(); sent_q.delete();
    endtask

    task automatic start(input int n);
        wr(A_COUNT, n - 1);
        ec = 0; cap = '0; first_edge_cyc = -1;
        next_reply();
        mon_on = 1'b1;
        en_cyc = cyc;
        wr(A_EN, 1);
    endtask

    task automatic push(input logic [15:0] w);
        sent_q.push_back(fit(w));
        wr(A_TXD, {16'd0, w});
    endtask

    task automatic stop();
        mon_on = 1'b0;
        wr(A_EN, 0);
        @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(A_STAT, v);
            if (!v[0]) return;
        end
        chk({req, " busy never cleared"}, 1, 0);
    endtask

    task automatic drain(input int n, input string req);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            rd(A_RXD, v);
            chk({req, " received word"}, v, (exp_rx_q.size() > 0) ? {16'd0, exp_rx_q.pop_front()} : 32'hDEAD);
        end
    endtask

    task automatic cmp_sent(input string req);
        chk({req, " frames seen by slave"}, got_q.size(), sent_q.size());
        for (int i = 0; i < sent_q.size() && i < got_q.size(); i++)
            chk({req, " slave captured word"}, got_q[i], sent_q[i]);
    endtask

    task automatic run_frames(input logic wide, input logic cpol, input logic cpha,
                              input logic [15:0] dv, input int n, input logic [15:0] seed);
        logic [31:0] v;
        configure(wide, cpol, cpha, dv);
        for (int i = 0; i < n + 1; i++) reply_q.push_back(16'h3C5A ^ (seed + 16'(i) * 16'h2469));
        start(n);
        for (int i = 0; i < n; i++) push(seed ^ (16'(i) * 16'h1357));
        wait_idle("R2");
        chk("R10 enable to first edge", first_edge_cyc - en_cyc, m_half + 3);
        chk("R9 idle level after transfer", sclk, cpol);
        chk("R2 exact frame count", got_q.size(), n);
        cmp_sent("R8");
        drain(n, "R9");
        rd(A_STAT, v);
        chk("R6 status after drain", v, 32'h4);
        stop();
    endtask

    logic done_flag = 0;

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(A_STAT, v);  chk("R6 reset status", v, 32'h4);
        chk("R7 reset selects", {28'd0, cs_n}, 32'hF);
        chk("R9 reset sclk", sclk, 0);
        rd(A_RXD, v);   chk("R13 empty read", v, 0);

        // Select register
        m_sel = 4'b0010; wr(A_SEL, 32'h2); @(negedge clk);
        chk("R7 select one", {28'd0, cs_n}, 32'hD);
        wr(A_SEL, 32'h6); @(negedge clk);
        chk("R7 multi-bit write ignored", {28'd0, cs_n}, 32'hD);
        wr(A_SEL, 32'h12); @(negedge clk);
        chk("R7 high-bit write ignored", {28'd0, cs_n}, 32'hD);
        m_sel = 4'b0000; wr(A_SEL, 0); @(negedge clk);
        chk("R7 deselect all", {28'd0, cs_n}, 32'hF);
        m_sel = 4'b0001; wr(A_SEL, 1);

        // All four modes, both widths, several divisors
        run_frames(0, 0, 0, 16'd4, 3, 16'hA5C3);
        run_frames(1, 1, 1, 16'd7, 2, 16'h9E11);
        run_frames(0, 0, 1, 16'd0, 3, 16'h5A0F);
        run_frames(1, 1, 0, 16'd1, 2, 16'hC001);
        run_frames(0, 1, 1, 16'd10, 1, 16'h0081);

        // Config frozen while enabled
        configure(0, 0, 0, 16'd2);
        reply_q.push_back(16'h0077); reply_q.push_back(16'h0000);
        start(1);
        wr(A_CTRL, 32'h7); wr(A_COUNT, 32'h5); wr(A_DIV, 32'h40);
        rd(A_CTRL, v);  chk("R3 control locked", v, 0);
        rd(A_COUNT, v); chk("R3 count locked", v, 0);
        rd(A_DIV, v);   chk("R3 divisor locked", v, 2);
        push(16'h00C4);
        wait_idle("R3");
        chk("R3 single frame", got_q.size(), 1);
        cmp_sent("R3");
        drain(1, "R3");
        stop();

        // Transmit underrun stall
        configure(1, 1, 0, 16'd5);
        for (int i = 0; i < 3; i++) reply_q.push_back(16'hB00B + 16'(i));
        start(2);
        push(16'h1234);
        repeat (150) @(negedge clk);
        rd(A_STAT, v);  chk("R11 busy while starved", v, 32'h1);
        chk("R11 sclk idle while starved", sclk, 1);
        chk("R11 one frame before stall", got_q.size(), 1);
        push(16'hFEDC);
        wait_idle("R11");
        cmp_sent("R11");
        drain(2, "R11");
        stop();

        // Receive full stall, transmit full flag, dropped push
        configure(0, 0, 0, 16'd2);
        for (int i = 0; i < 65; i++) reply_q.push_back(16'h0040 + 16'(i * 3));
        start(64);
        for (int i = 0; i < 32; i++) push(16'h0011 * 16'(i));
        repeat (800) @(negedge clk);
        rd(A_STAT, v);  chk("R12 busy with rx full", v, 32'h1);
        chk("R12 frames before stall", got_q.size(), 32);
        for (int i = 0; i < 32; i++) push(16'h0080 + 16'(i));
        rd(A_STAT, v);  chk("R5 tx full flag", v, 32'h3);
        wr(A_TXD, 32'h00EE);
        repeat (60) @(negedge clk);
        chk("R12 still stalled", got_q.size(), 32);
        drain(32, "R12");
        wait_idle("R12");
        drain(32, "R12");
        cmp_sent("R5");
        rd(A_RXD, v);   chk("R13 empty read after drain", v, 0);
        rd(A_STAT, v);  chk("R13 status unchanged", v, 32'h4);
        stop();

        // Abort mid-transfer, writes while disabled dropped
        configure(1, 0, 0, 16'd8);
        for (int i = 0; i < 4; i++) reply_q.push_back(16'h7E7E);
        start(10);
        push(16'hAAAA); push(16'h5555); push(16'h0F0F);
        repeat (20) @(negedge clk);
        mon_on = 1'b0;
        wr(A_EN, 0);
        @(negedge clk);
        chk("R4 sclk idle after abort", sclk, 0);
        rd(A_STAT, v);  chk("R4 status after abort", v, 32'h4);
        wr(A_TXD, 32'h1111);
        wr(A_COUNT, 0);
        first_edge_cyc = -1; ec = 0; mon_on = 1'b1;
        wr(A_EN, 1);
        repeat (60) @(negedge clk);
        chk("R4 no frame from flushed or dropped data", first_edge_cyc, -1);
        rd(A_STAT, v);  chk("R4 waiting with empty fifos", v, 32'h5);
        stop();

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, bad_cnt);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            cmp_cnt++;
            bad_cnt++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, bad_cnt);
            $finish;
        end
    end
endmodule